// File: doc/BRIEF.md
# Memory Access Wait-State Generator

This block sits beside a processor's bus port and decides how long each memory access takes. For every request it works out a cycle count. The count depends on the memory the address falls in (on-chip SRAM or flash), on whether the access is an instruction fetch or a data transfer, on the instruction width (16 or 32 bits), and on the flash clock-divider setting. After that many cycles it raises a single-cycle ready pulse. Taken branches also carry a pipeline-refill penalty. That penalty is added to the wait and is reported next to the ready pulse, so the core can account for the bubble.

A request is taken only when the block is idle: busy is low and no ready pulse is being shown. The request attributes are latched when the request is taken, so changes on those inputs during the wait have no effect. Requests that arrive while an access is in flight are not stored. The requester has to keep the request valid until the block accepts it.

Top module: `wsg_top`

## Requirements
- R1: While reset is active, and in the first cycle after it, ready is low, busy is low and refill_stall is 0.
- R2: A request is accepted at a clock edge where req_valid is high, busy is low and ready is low. Busy is high from that edge until the edge where ready rises. Ready rises N edges after the accepting edge, where N is the access cost set out in R3 to R8.
- R3: An instruction fetch (req_kind=0) from SRAM (req_region=0) with no branch costs N=1.
- R4: A 16-bit fetch (req_wide=0) from flash (req_region=1) costs N=1 at every req_cd value.
- R5: A 32-bit fetch (req_wide=1) from flash costs N=2 when req_cd is 0, and N=1 when req_cd is greater than 0.
- R6: A data access (req_kind=1) costs N=2 in SRAM. In flash it costs N=4 (base cycle, one dead cycle, two data cycles), whatever req_cd and req_wide are.
- R7: A fetch from flash with req_branch=1 adds a refill stall S to N. S is 5 when req_cd is 0 and 1 otherwise.
- R8: A fetch from SRAM with req_branch=1 adds a refill stall S=2 to N.
- R9: req_branch has no effect on data accesses: N is as in R6 and refill_stall shows 0.
- R10: Ready is high for exactly one cycle per accepted request. refill_stall shows the stall S of that request during that cycle and 0 in every other cycle.
- R11: Requests are never queued. req_valid has no effect while busy or ready is high, and changes to the request attributes after acceptance do not change the cost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_region | input | 1 | 0 = SRAM, 1 = flash |
| req_kind | input | 1 | 0 = instruction fetch, 1 = data access |
| req_wide | input | 1 | 0 = 16-bit instructions, 1 = 32-bit instructions |
| req_cd | input | CD_W (3) | Flash clock-divider setting |
| req_branch | input | 1 | Fetch follows a taken branch |
| ready | output | 1 | One-cycle completion pulse |
| busy | output | 1 | An access is being counted |
| refill_stall | output | STALL_W (4) | Refill penalty, valid while ready is high |

## Verification
Ready is registered. It rises exactly N rising edges after the edge that accepts the request, and busy falls on that same edge. Refill_stall appears together with ready. The bench model marks the accepting edge, records the cycle at which ready is due, and predicts ready, busy and refill_stall for every cycle. Inputs change on falling edges and all three outputs are compared on each falling edge, which checks both that each result arrives on time and that nothing arrives early or late. Holding a request through the ready cycle and changing attributes while busy cover the hold-off cases.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
    localparam int CNT_W   = 4;
    localparam int STALL_W = 4;

    typedef enum logic { RGN_SRAM = 1'b0, RGN_FLASH = 1'b1 } region_e;
    typedef enum logic { KIND_FETCH = 1'b0, KIND_DATA = 1'b1 } kind_e;

    typedef struct packed {
        logic               busy;
        logic               ready;
        logic [CNT_W-1:0]   cnt;
        logic [STALL_W-1:0] stall_pend;
        logic [STALL_W-1:0] stall_out;
    } seq_state_t;
endpackage

// File: rtl/wsg_cost.sv
module wsg_cost
    import wsg_pkg::*;
#(
    parameter int CD_W            = 3,
    parameter int SRAM_FETCH      = 1,
    parameter int SRAM_DATA_EXTRA = 1,
    parameter int FLASH_FETCH     = 1,
    parameter int FLASH_WIDE_CD0  = 2,
    parameter int FLASH_DEAD      = 1,
    parameter int FLASH_DATA_EXT  = 2,
    parameter int SRAM_REFILL     = 2,
    parameter int FLASH_DECODE    = 1,
    parameter int FLASH_FILL_CD0  = 4
) (
    input  region_e             region,
    input  kind_e               kind,
    input  logic                wide,
    input  logic [CD_W-1:0]     cd,
    input  logic                branch,
    output logic [CNT_W-1:0]    cycles,
    output logic [STALL_W-1:0]  stall
);
    localparam logic [CNT_W-1:0]   C_SRAM_F  = CNT_W'(SRAM_FETCH);
    localparam logic [CNT_W-1:0]   C_SRAM_D  = CNT_W'(SRAM_FETCH + SRAM_DATA_EXTRA);
    localparam logic [CNT_W-1:0]   C_FLS_F   = CNT_W'(FLASH_FETCH);
    localparam logic [CNT_W-1:0]   C_FLS_W0  = CNT_W'(FLASH_WIDE_CD0);
    localparam logic [CNT_W-1:0]   C_FLS_D   = CNT_W'(FLASH_FETCH + FLASH_DEAD + FLASH_DATA_EXT);
    localparam logic [STALL_W-1:0] S_SRAM    = STALL_W'(SRAM_REFILL);
    localparam logic [STALL_W-1:0] S_FLS_CD0 = STALL_W'(FLASH_DECODE + FLASH_FILL_CD0);
    localparam logic [STALL_W-1:0] S_FLS     = STALL_W'(FLASH_DECODE);

    logic                cd_zero;
    logic [CNT_W-1:0]    base;
    logic [STALL_W-1:0]  refill;

    assign cd_zero = (cd == '0);

    always_comb begin
        base   = C_SRAM_F;
        refill = '0;
        unique case ({region, kind})
            {RGN_SRAM,  KIND_FETCH}: base = C_SRAM_F;
            {RGN_SRAM,  KIND_DATA }: base = C_SRAM_D;
            {RGN_FLASH, KIND_FETCH}: base = (wide && cd_zero) ? C_FLS_W0 : C_FLS_F;
            {RGN_FLASH, KIND_DATA }: base = C_FLS_D;
            default:                 base = C_SRAM_F;
        endcase
        if (branch && kind == KIND_FETCH) begin
            if (region == RGN_FLASH) refill = cd_zero ? S_FLS_CD0 : S_FLS;
            else                     refill = S_SRAM;
        end
    end

    assign cycles = base + CNT_W'(refill);
    assign stall  = refill;
endmodule

// File: rtl/wsg_seq.sv
module wsg_seq
    import wsg_pkg::*;
#(
    parameter int MAX_COST = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [CNT_W-1:0]    cost_cycles,
    input  logic [STALL_W-1:0]  cost_stall,
    output logic                ready,
    output logic                busy,
    output logic [STALL_W-1:0]  refill_stall
);
    seq_state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.ready     = 1'b0;
        st_d.stall_out = '0;
        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy      = 1'b0;
                st_d.ready     = 1'b1;
                st_d.stall_out = st_q.stall_pend;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (req_valid && !st_q.ready) begin
            st_d.busy       = 1'b1;
            st_d.cnt        = cost_cycles - 1'b1;
            st_d.stall_pend = cost_stall;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ready        = st_q.ready;
    assign busy         = st_q.busy;
    assign refill_stall = st_q.stall_out;

    // R10
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    // R2
    busy_ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && ready));

    // R10
    stall_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> refill_stall == '0);

    // R11
    accept_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req_valid) |=> !busy);

    // R11
    no_accept_on_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !busy);

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> st_q.cnt < CNT_W'(MAX_COST));
endmodule

// File: rtl/wsg_top.sv
module wsg_top
    import wsg_pkg::*;
#(
    parameter int CD_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_region,
    input  logic                req_kind,
    input  logic                req_wide,
    input  logic [CD_W-1:0]     req_cd,
    input  logic                req_branch,
    output logic                ready,
    output logic                busy,
    output logic [STALL_W-1:0]  refill_stall
);
    localparam int MAX_COST = 2 + 1 + 4 + 2;

    logic [CNT_W-1:0]   cost_cycles;
    logic [STALL_W-1:0] cost_stall;

    wsg_cost #(.CD_W(CD_W)) i_cost (
        .region (region_e'(req_region)),
        .kind   (kind_e'(req_kind)),
        .wide   (req_wide),
        .cd     (req_cd),
        .branch (req_branch),
        .cycles (cost_cycles),
        .stall  (cost_stall)
    );

    wsg_seq #(.MAX_COST(MAX_COST)) i_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .cost_cycles  (cost_cycles),
        .cost_stall   (cost_stall),
        .ready        (ready),
        .busy         (busy),
        .refill_stall (refill_stall)
    );

    // R9
    data_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ready && req_valid && req_kind) |-> cost_stall == '0);
endmodule

// File: tb/test_wsg_top.sv
module test_wsg_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_region = 1'b0;
    logic       req_kind = 1'b0;
    logic       req_wide = 1'b0;
    logic [2:0] req_cd = 3'd0;
    logic       req_branch = 1'b0;
    logic       ready;
    logic       busy;
    logic [3:0] refill_stall;

    int checks = 0;
    int failures = 0;
    int wd = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    wsg_top i_wsg_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_region(req_region),
        .req_kind(req_kind), .req_wide(req_wide), .req_cd(req_cd),
        .req_branch(req_branch), .ready(ready), .busy(busy),
        .refill_stall(refill_stall)
    );

    // reference model: cycle index of acceptance, due cycle of ready
    int  cyc = 0;
    int  due = 0;
    int  pend = 0;
    bit  m_busy = 0;
    bit  m_ready = 0;
    int  m_stall = 0;

    function automatic void cost_of(input bit rg, input bit kd, input bit wd_i,
                                    input int cd, input bit br,
                                    output int n, output int s);
        s = 0;
        if (kd) n = rg ? 4 : 2;                       // R6
        else if (!rg) n = 1;                          // R3
        else if (wd_i && cd == 0) n = 2;              // R5
        else n = 1;                                   // R4
        if (br && !kd) s = rg ? ((cd == 0) ? 5 : 1) : 2;   // R7 R8 R9
        n = n + s;
    endfunction

    always @(posedge clk) begin
        bit was_ready;
        int n, s;
        if (!rst_n) begin
            cyc = 0; m_busy = 0; m_ready = 0; m_stall = 0;
        end else begin
            cyc = cyc + 1;
            was_ready = m_ready;
            m_ready = 0;
            m_stall = 0;
            if (m_busy) begin
                if (cyc == due) begin
                    m_busy = 0; m_ready = 1; m_stall = pend;
                end
            end else if (req_valid && !was_ready) begin
                cost_of(req_region, req_kind, req_wide, int'(req_cd), req_branch, n, s);
                m_busy = 1; due = cyc + n; pend = s;
            end
        end
    end

    always @(negedge clk) begin
        checks++;
        if (ready !== m_ready || busy !== m_busy || int'(refill_stall) !== m_stall) begin
            failures++;
            $display("FAIL %s cyc=%0d ready/busy/stall actual=%0b/%0b/%0d expected=%0b/%0b/%0d",
                     cur_req, cyc, ready, busy, refill_stall, m_ready, m_busy, m_stall);
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 20000) begin
            failures++;
            $display("FAIL watchdog expired during %s", cur_req);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic do_req(input bit rg, input bit kd, input bit wide_i, input logic [2:0] cd,
                          input bit br, input string tag, input bit hold, input bit scramble);
        @(negedge clk);
        cur_req = tag;
        req_region = rg; req_kind = kd; req_wide = wide_i; req_cd = cd; req_branch = br;
        req_valid = 1'b1;
        @(negedge clk);
        if (scramble) begin
            req_region = ~rg; req_kind = ~kd; req_wide = ~wide_i;
            req_cd = ~cd; req_branch = ~br;
        end
        while (!ready) @(negedge clk);
        if (hold) @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // SRAM and flash fetches
        do_req(0, 0, 0, 3'd0, 0, "R3",  0, 0);
        do_req(0, 0, 1, 3'd2, 0, "R3",  0, 0);
        do_req(1, 0, 0, 3'd0, 0, "R4",  0, 0);
        do_req(1, 0, 0, 3'd5, 0, "R4",  0, 0);
        do_req(1, 0, 1, 3'd0, 0, "R5",  0, 0);
        do_req(1, 0, 1, 3'd1, 0, "R5",  0, 0);
        do_req(1, 0, 1, 3'd7, 0, "R5",  0, 0);
        // data accesses
        do_req(0, 1, 0, 3'd0, 0, "R6",  0, 0);
        do_req(1, 1, 0, 3'd0, 0, "R6",  0, 0);
        do_req(1, 1, 1, 3'd4, 0, "R6",  0, 0);
        // branches
        do_req(1, 0, 1, 3'd0, 1, "R7",  0, 0);
        do_req(1, 0, 0, 3'd3, 1, "R7",  0, 0);
        do_req(0, 0, 0, 3'd0, 1, "R8",  0, 0);
        do_req(0, 0, 1, 3'd6, 1, "R8",  0, 0);
        do_req(1, 1, 0, 3'd0, 1, "R9",  0, 0);
        do_req(0, 1, 1, 3'd2, 1, "R9",  0, 0);
        // hold-off and latching
        do_req(0, 0, 0, 3'd0, 0, "R10", 1, 0);
        do_req(1, 1, 0, 3'd2, 0, "R11", 1, 1);
        do_req(0, 0, 1, 3'd1, 1, "R11", 0, 1);
        do_req(1, 0, 1, 3'd0, 1, "R2",  1, 0);
        // back-to-back: request held continuously across several accesses
        @(negedge clk);
        cur_req = "R11";
        req_region = 1; req_kind = 1; req_branch = 0; req_valid = 1'b1;
        repeat (14) @(negedge clk);
        req_valid = 1'b0;
        repeat (8) @(negedge clk);
        // reset in the middle of an access
        cur_req = "R1";
        req_region = 1; req_kind = 0; req_wide = 1; req_cd = 0; req_branch = 1; req_valid = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule